// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block turns an instruction fetch PC into a physical address and classifies that address. It looks at the PC, a flag that marks the request as already physical, the current processor mode, and the result of a lookup in a translation buffer that lives outside the block. From these it picks one of four routes:

- a firmware-mode PC, marked by bit 0, which bypasses translation;
- a physical pass-through;
- a kernel-only direct-mapped window;
- a page-table translation checked against the entry's execute-permission mask.

The physical address is then checked against the implemented range and against the uncached-space bit. A fetch must never reach uncached space, so every fetch that lands there faults. One that lands in the internal-register sub-space faults differently.

Each request is taken in one cycle and answered in the next. The fetch unit drives `req_valid` with the PC and mode, and feeds in the translation buffer's answer in the same cycle. While a request is present, the block raises `tlb_lookup` only if that answer is actually used.

Top module: `ifx_xlate`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_paddr`, `rsp_uncached` and `rsp_fault` are all 0. A request held on `req_valid` at a rising edge gives `rsp_valid` = 1 after that edge. With no request, `rsp_valid` is 0 after the edge.
- R2: A PC with bit 0 set is a firmware-mode fetch. Its address is `pc` with bits 1:0 cleared, cut to the low 44 bits. It gives fault 0 and `rsp_uncached` = 0, even when bit 43 is set or the physical flag is set. `tlb_lookup` stays 0.
- R3: With `phys_req` = 1 (and `pc[0]` = 0), the physical address is `pc` unchanged. It then goes through the range check and the cacheability checks. `tlb_lookup` stays 0.
- R4: When `pc[47:41]` = 7'h7E, kernel mode (mode code 0) gives `pc[39:0]`. Bits 43:40 of the result are all ones if `pc[40]` = 1 and all zeros otherwise. No lookup is made.
- R5: In that window, any mode other than kernel (codes 1, 2, 3) gives fault code 1, an access violation.
- R6: On the translated route `tlb_lookup` = 1. If `tlb_hit` = 0, the result is fault code 2, a page miss.
- R7: On a hit, the address is `tlb_ppn` shifted left by 13, plus `pc[12:0]` with bits 1:0 cleared.
- R8: On a hit, `tlb_xre[mode]` must be 1. If it is 0, the result is fault code 1.
- R9: If any physical-address bit at or above bit 44 is set, the result is fault code 3, a machine check. This takes priority over the uncached-space checks.
- R10: If bit 43 is set and bits 42:39 equal 4'hA, the result is fault code 4, internal-register space.
- R11: Any other address with bit 43 set gives fault code 5, an uncached fetch. In that case `rsp_uncached` = 1 and `rsp_paddr` is the address with bits 42:35 cleared.
- R12: For fault codes 1 to 4, `rsp_paddr` = 0 and `rsp_uncached` = 0. Fault code 0 means no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request present this cycle |
| pc | input | 64 | Fetch address |
| phys_req | input | 1 | Request address is already physical |
| mode | input | 2 | Current mode: 0 kernel, 1 executive, 2 supervisor, 3 user |
| tlb_hit | input | 1 | Translation buffer found a matching entry |
| tlb_ppn | input | 32 | Physical page number of the matching entry |
| tlb_xre | input | 4 | Read/execute enable mask of the entry, one bit per mode |
| tlb_lookup | output | 1 | The translation buffer result is used for this request |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_paddr | output | 44 | Physical address |
| rsp_uncached | output | 1 | Address was in uncached space and was rewritten |
| rsp_fault | output | 3 | Fault code (0 none, 1 access, 2 miss, 3 machine check, 4 register space, 5 uncached fetch) |

## Verification
The bench aims at route priority.

- A firmware PC with bit 43 set checks that the cacheability stage is skipped. A design that ran that stage would report an uncached fetch.
- A superpage address with bit 40 set should come out as an uncached fetch. If the sign extension were wrong, the fetch would look cacheable.
- An out-of-range address with bit 43 also set must give a machine check. If the checks ran in the wrong order, it would give an uncached fault instead.
- Bits 1:0 must be cleared on the translated route but kept on the physical route.
- Permission is checked in both kernel and user mode. An off-by-one in the mask index would then grant or deny the wrong fetch.

// File: rtl/ifx_pkg.sv
package ifx_pkg;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_ACV     = 3'd1,
    FLT_PAGE    = 3'd2,
    FLT_MCHK    = 3'd3,
    FLT_UNIMP   = 3'd4,
    FLT_IOFETCH = 3'd5
  } ifx_fault_e;

  typedef enum logic [1:0] {
    MODE_KERNEL = 2'd0,
    MODE_EXEC   = 2'd1,
    MODE_SUPER  = 2'd2,
    MODE_USER   = 2'd3
  } ifx_mode_e;

  localparam int MODE_N = 4;

endpackage

// File: rtl/ifx_route.sv
// Picks the translation route and forms the raw (untruncated) physical address.
module ifx_route
  import ifx_pkg::*;
#(
  parameter int VA_W   = 64,
  parameter int PA_W   = 44,
  parameter int PG_SH  = 13,
  parameter int PPN_W  = 32,
  parameter int SP_HI  = 47,
  parameter int SP_LO  = 41,
  parameter int SP_TAG = 'h7E,
  parameter int SX_BIT = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VA_W-1:0]   pc,
  input  logic              phys_req,
  input  logic [1:0]        mode,
  input  logic              tlb_hit,
  input  logic [PPN_W-1:0]  tlb_ppn,
  input  logic [MODE_N-1:0] tlb_xre,
  output logic [VA_W-1:0]   pa_raw,
  output ifx_fault_e        pre_fault,
  output logic              is_pal,
  output logic              need_lookup
);
  localparam int SP_W = SP_HI - SP_LO + 1;

  // firmware PC: clear the two low bits, keep the implemented range
  function automatic logic [VA_W-1:0] pal_addr(input logic [VA_W-1:0] va);
    logic [VA_W-1:0] r;
    r = '0;
    r[PA_W-1:2] = va[PA_W-1:2];
    return r;
  endfunction

  // superpage: low bits pass through, upper implemented bits copy bit SX_BIT
  function automatic logic [VA_W-1:0] sp_addr(input logic [VA_W-1:0] va);
    logic [VA_W-1:0] r;
    r = '0;
    r[SX_BIT-1:0] = va[SX_BIT-1:0];
    if (va[SX_BIT]) r[PA_W-1:SX_BIT] = '1;
    return r;
  endfunction

  // page translation: page number above the offset, offset word-aligned
  function automatic logic [VA_W-1:0] page_addr(input logic [PPN_W-1:0] ppn,
                                                input logic [VA_W-1:0]  va);
    logic [VA_W-1:0] r;
    r = '0;
    r[PG_SH+PPN_W-1:PG_SH] = ppn;
    r[PG_SH-1:2] = va[PG_SH-1:2];
    return r;
  endfunction

  logic sp_win;
  assign is_pal = pc[0];
  assign sp_win = (pc[SP_HI:SP_LO] == SP_W'(SP_TAG));
  assign need_lookup = !is_pal && !phys_req && !sp_win;

  always_comb begin
    pa_raw    = '0;
    pre_fault = FLT_NONE;
    if (is_pal) begin
      pa_raw = pal_addr(pc);
    end else if (phys_req) begin
      pa_raw = pc;
    end else if (sp_win) begin
      if (mode != MODE_KERNEL) pre_fault = FLT_ACV;
      else                     pa_raw    = sp_addr(pc);
    end else if (!tlb_hit) begin
      pre_fault = FLT_PAGE;
    end else if (!tlb_xre[mode]) begin
      pre_fault = FLT_ACV;
    end else begin
      pa_raw = page_addr(tlb_ppn, pc);
    end
  end

  p_pal_no_lookup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_pal |-> !need_lookup && pre_fault == FLT_NONE);
  p_lookup_only_if_used_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_fault == FLT_PAGE) |-> need_lookup);

endmodule

// File: rtl/ifx_classify.sv
// Range check and uncached-space classification of the raw physical address.
module ifx_classify
  import ifx_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int PA_W      = 44,
  parameter int UC_BIT    = 43,
  parameter int UC_CLR_HI = 42,
  parameter int UC_CLR_LO = 35,
  parameter int IPR_HI    = 42,
  parameter int IPR_LO    = 39,
  parameter int IPR_TAG   = 'hA
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [VA_W-1:0] pa_raw,
  input  ifx_fault_e      pre_fault,
  input  logic            is_pal,
  output logic [PA_W-1:0] pa_out,
  output logic            uncached,
  output ifx_fault_e      fault
);
  localparam int IPR_W = IPR_HI - IPR_LO + 1;

  function automatic logic [PA_W-1:0] uc_rewrite(input logic [PA_W-1:0] a);
    logic [PA_W-1:0] r;
    r = a;
    r[UC_CLR_HI:UC_CLR_LO] = '0;
    return r;
  endfunction

  logic [PA_W-1:0] pa;
  logic            out_of_range, uc_space, reg_space;

  assign pa           = pa_raw[PA_W-1:0];
  assign out_of_range = |pa_raw[VA_W-1:PA_W];
  assign uc_space     = pa[UC_BIT];
  assign reg_space    = (pa[IPR_HI:IPR_LO] == IPR_W'(IPR_TAG));

  always_comb begin
    pa_out   = '0;
    uncached = 1'b0;
    fault    = pre_fault;
    if (pre_fault != FLT_NONE) begin
      fault = pre_fault;
    end else if (is_pal) begin
      pa_out = pa;
    end else if (out_of_range) begin
      fault = FLT_MCHK;
    end else if (uc_space && reg_space) begin
      fault = FLT_UNIMP;
    end else if (uc_space) begin
      uncached = 1'b1;
      pa_out   = uc_rewrite(pa);
      fault    = FLT_IOFETCH;
    end else begin
      pa_out = pa;
    end
  end

  p_range_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_fault == FLT_NONE && !is_pal && out_of_range) |-> fault == FLT_MCHK);
  p_uc_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
    uncached |-> pa_out[UC_CLR_HI:UC_CLR_LO] == '0 && pa_out[UC_BIT]);

endmodule

// File: rtl/ifx_xlate.sv
module ifx_xlate
  import ifx_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int PA_W      = 44,
  parameter int PG_SH     = 13,
  parameter int PPN_W     = 32,
  parameter int SP_HI     = 47,
  parameter int SP_LO     = 41,
  parameter int SP_TAG    = 'h7E,
  parameter int SX_BIT    = 40,
  parameter int UC_BIT    = 43,
  parameter int UC_CLR_HI = 42,
  parameter int UC_CLR_LO = 35,
  parameter int IPR_HI    = 42,
  parameter int IPR_LO    = 39,
  parameter int IPR_TAG   = 'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   pc,
  input  logic              phys_req,
  input  logic [1:0]        mode,
  input  logic              tlb_hit,
  input  logic [PPN_W-1:0]  tlb_ppn,
  input  logic [MODE_N-1:0] tlb_xre,
  output logic              tlb_lookup,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_uncached,
  output logic [2:0]        rsp_fault
);
  localparam int SP_W = SP_HI - SP_LO + 1;

  logic [VA_W-1:0] pa_raw;
  ifx_fault_e      pre_fault, fault_c;
  logic            is_pal, need_lookup, unc_c;
  logic [PA_W-1:0] pa_c;

  ifx_route #(
    .VA_W(VA_W), .PA_W(PA_W), .PG_SH(PG_SH), .PPN_W(PPN_W),
    .SP_HI(SP_HI), .SP_LO(SP_LO), .SP_TAG(SP_TAG), .SX_BIT(SX_BIT)
  ) u_route (
    .clk(clk), .rst_n(rst_n), .pc(pc), .phys_req(phys_req), .mode(mode),
    .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn), .tlb_xre(tlb_xre),
    .pa_raw(pa_raw), .pre_fault(pre_fault), .is_pal(is_pal),
    .need_lookup(need_lookup)
  );

  ifx_classify #(
    .VA_W(VA_W), .PA_W(PA_W), .UC_BIT(UC_BIT), .UC_CLR_HI(UC_CLR_HI),
    .UC_CLR_LO(UC_CLR_LO), .IPR_HI(IPR_HI), .IPR_LO(IPR_LO), .IPR_TAG(IPR_TAG)
  ) u_class (
    .clk(clk), .rst_n(rst_n), .pa_raw(pa_raw), .pre_fault(pre_fault),
    .is_pal(is_pal), .pa_out(pa_c), .uncached(unc_c), .fault(fault_c)
  );

  assign tlb_lookup = req_valid && need_lookup;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_paddr    <= '0;
      rsp_uncached <= 1'b0;
      rsp_fault    <= FLT_NONE;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_paddr    <= pa_c;
        rsp_uncached <= unc_c;
        rsp_fault    <= fault_c;
      end
    end
  end

  p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_idle_no_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_pal_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pc[0]) |=> rsp_fault == FLT_NONE && !rsp_uncached && rsp_paddr[1:0] == 2'b00);
  p_sp_user_acv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pc[0] && !phys_req && pc[SP_HI:SP_LO] == SP_W'(SP_TAG) && mode != MODE_KERNEL)
      |=> rsp_fault == FLT_ACV);
  p_fault_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault inside {FLT_ACV, FLT_PAGE, FLT_MCHK, FLT_UNIMP})
      |-> rsp_paddr == '0 && !rsp_uncached);
  p_iofetch_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == FLT_IOFETCH) |-> rsp_uncached && rsp_paddr[UC_BIT]);

endmodule

// File: tb/sim_ifx_xlate.sv
module sim_ifx_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] pc = '0;
  logic        phys_req = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        tlb_hit = 1'b0;
  logic [31:0] tlb_ppn = '0;
  logic [3:0]  tlb_xre = '0;
  logic        tlb_lookup, rsp_valid, rsp_uncached;
  logic [43:0] rsp_paddr;
  logic [2:0]  rsp_fault;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ifx_xlate u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pc(pc),
    .phys_req(phys_req), .mode(mode), .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn),
    .tlb_xre(tlb_xre), .tlb_lookup(tlb_lookup), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_uncached(rsp_uncached), .rsp_fault(rsp_fault)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one request: inputs set just after an edge, result read just after the next
  task automatic xlate(input logic [63:0] a, input bit ph, input logic [1:0] m,
                       input bit hit, input logic [31:0] ppn, input logic [3:0] xre,
                       input logic [43:0] e_pa, input bit e_unc, input logic [2:0] e_flt,
                       input bit e_lk, input string tag);
    req_valid = 1'b1; pc = a; phys_req = ph; mode = m;
    tlb_hit = hit; tlb_ppn = ppn; tlb_xre = xre;
    #1;
    chk(tlb_lookup == e_lk, {tag, " lookup"}, 64'(tlb_lookup), 64'(e_lk));
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, {tag, " valid R1"}, 64'(rsp_valid), 64'd1);
    chk(rsp_fault == e_flt, {tag, " fault"}, 64'(rsp_fault), 64'(e_flt));
    chk(rsp_paddr == e_pa, {tag, " paddr"}, 64'(rsp_paddr), 64'(e_pa));
    chk(rsp_uncached == e_unc, {tag, " uncached"}, 64'(rsp_uncached), 64'(e_unc));
  endtask

  task automatic t_reset();
    chk(rsp_valid == 0, "R1 reset valid", 64'(rsp_valid), 0);
    chk(rsp_paddr == 0, "R1 reset paddr", 64'(rsp_paddr), 0);
    chk(rsp_fault == 0, "R1 reset fault", 64'(rsp_fault), 0);
    chk(rsp_uncached == 0, "R1 reset uncached", 64'(rsp_uncached), 0);
  endtask

  task automatic t_idle();
    @(posedge clk); #1;
    chk(rsp_valid == 0, "R1 idle no response", 64'(rsp_valid), 0);
  endtask

  task automatic t_pal();
    xlate(64'hFFFF_F000_1234_5677, 0, 2'd3, 0, 0, 0, 44'h000_1234_5674, 0, 0, 0, "R2 pal basic");
    xlate(64'h0000_0800_0000_1001, 1, 2'd3, 0, 0, 0, 44'h800_0000_1000, 0, 0, 0, "R2 pal uncached bit ignored");
  endtask

  task automatic t_phys();
    xlate(64'h0000_0000_1234_567A, 1, 2'd3, 0, 0, 0, 44'h000_1234_567A, 0, 0, 0, "R3 phys pass");
    xlate(64'h0000_1000_0000_0000, 1, 2'd0, 0, 0, 0, 44'h0, 0, 3'd3, 0, "R9 phys out of range");
    xlate(64'h0000_1800_0000_0000, 1, 2'd0, 0, 0, 0, 44'h0, 0, 3'd3, 0, "R9 mchk beats uncached");
  endtask

  task automatic t_superpage();
    xlate(64'h0000_FC00_1234_5678, 0, 2'd0, 0, 0, 0, 44'h000_1234_5678, 0, 0, 0, "R4 sp kernel bit40 clear");
    xlate(64'h0000_FD00_0000_2000, 0, 2'd0, 0, 0, 0, 44'h800_0000_2000, 1, 3'd5, 0, "R4 sp kernel bit40 set");
    xlate(64'h0000_FC00_1234_5678, 0, 2'd3, 1, 0, 4'hF, 44'h0, 0, 3'd1, 0, "R5 sp user");
    xlate(64'h0000_FC00_1234_5678, 0, 2'd1, 1, 0, 4'hF, 44'h0, 0, 3'd1, 0, "R5 sp executive");
  endtask

  task automatic t_tlb();
    xlate(64'h0000_0000_0040_3ABE, 0, 2'd3, 1, 32'h0000_1234, 4'b1000, 44'h000_0246_9ABC, 0, 0, 1, "R7 hit user");
    xlate(64'h0000_0000_0040_3ABE, 0, 2'd1, 1, 32'h0000_1234, 4'b1000, 44'h0, 0, 3'd1, 1, "R8 exec denied");
    xlate(64'h0000_0000_0040_3ABE, 0, 2'd0, 1, 32'h0000_1234, 4'b0001, 44'h000_0246_9ABC, 0, 0, 1, "R8 kernel allowed");
    xlate(64'h0000_0000_0040_3ABE, 0, 2'd0, 1, 32'h0000_1234, 4'b1110, 44'h0, 0, 3'd1, 1, "R8 kernel denied");
    xlate(64'h0000_0000_0040_3ABE, 0, 2'd0, 0, 32'h0000_1234, 4'hF, 44'h0, 0, 3'd2, 1, "R6 miss");
    xlate(64'h0000_0000_0000_6004, 0, 2'd0, 1, 32'h8000_0000, 4'hF, 44'h0, 0, 3'd3, 1, "R9 tlb out of range");
  endtask

  task automatic t_cacheability();
    xlate(64'h0000_0812_3456_7890, 1, 2'd0, 0, 0, 0, 44'h802_3456_7890, 1, 3'd5, 0, "R11 phys uncached");
    xlate(64'h0000_0000_0000_6004, 0, 2'd0, 1, 32'h4000_0000, 4'hF, 44'h800_0000_0004, 1, 3'd5, 1, "R11 tlb uncached");
    xlate(64'h0000_0D00_0000_0040, 1, 2'd0, 0, 0, 0, 44'h0, 0, 3'd4, 0, "R10 R12 register space");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    t_reset();
    t_idle();
    t_pal();
    t_phys();
    t_superpage();
    t_tlb();
    t_cacheability();
    t_idle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule